// File: doc/BRIEF.md
# Clocked Serial Receiver with Ready Handshake

This block is the receive half of a clock-synchronous serial port that runs as a slave. A remote transmitter supplies the shift clock. On each rising edge of that clock the block samples one data bit, least significant bit first. After eight bits it copies the assembled byte into a receive buffer. It then raises a receive-complete flag and an interrupt request. A ready output, `rts_out`, is active low and tells the transmitter when the buffer can take another byte.

The port receives only when it is armed. Both enable inputs must be high, and a dummy byte must have been written to the transmit buffer, which clears `txbuf_empty`. At the start of a frame the dummy byte is considered taken, so `txbuf_empty` returns to 1. Software must write a new dummy byte before each frame.

Reading the buffer clears the complete flag. That read, and not the end of the frame, is what drops `rts_out` low again. A frame that completes while the previous byte is still unread sets a sticky overrun flag and replaces the buffer contents. The serial clock idles high. Each half period of the serial clock must last at least two system clocks. The serial clock and data pass through matching two-flop synchronizers.

Top module: `sync_serial_rx`

## Requirements
- R1: After reset, `rx_done`, `irq_req`, `ovr_err` and `rx_data` are 0 and `txbuf_empty` is 1. `rts_out` is 1 while `rx_en` is 0 and 0 once `rx_en` is 1.
- R2: A frame starts on a falling edge of `sclk_in` while the port is armed and idle. Bits are sampled from `rxd_in` on the next eight rising edges of `sclk_in`, and the first bit sampled becomes bit 0 of the byte.
- R3: The port is armed only while `tx_en`=1, `rx_en`=1 and `txbuf_empty`=0. Serial clock activity at any other time leaves `rx_done` and `rx_data` unchanged.
- R4: A `txbuf_wr` pulse drives `txbuf_empty` to 0. The start of a frame drives it back to 1.
- R5: On the eighth rising edge the byte is loaded into `rx_data`, and both `rx_done` and `irq_req` go to 1.
- R6: A `rxbuf_rd` pulse clears `rx_done`.
- R7: `rts_out` goes to 1 at frame start and does not change at frame completion. It returns to 0 only when `rx_done` falls because of a read. It is forced to 1 whenever `rx_en`=0.
- R8: A frame that completes while `rx_done`=1 sets `ovr_err` and overwrites `rx_data`. `ovr_err` stays set until an `ovr_clr` pulse.
- R9: `irq_req` stays set until an `irq_clr` pulse (an interrupt acknowledge or a software clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable bit |
| rx_en | input | 1 | Receive enable bit |
| txbuf_wr | input | 1 | Dummy write to the transmit buffer (pulse) |
| rxbuf_rd | input | 1 | Read of the receive buffer (pulse) |
| irq_clr | input | 1 | Interrupt acknowledge or software clear (pulse) |
| ovr_clr | input | 1 | Clears the overrun flag (pulse) |
| sclk_in | input | 1 | External serial clock, idles high |
| rxd_in | input | 1 | Serial data in |
| rx_data | output | DW | Receive buffer |
| rx_done | output | 1 | Receive-complete flag |
| irq_req | output | 1 | Receive interrupt request |
| ovr_err | output | 1 | Sticky overrun flag |
| txbuf_empty | output | 1 | Transmit buffer empty flag |
| rts_out | output | 1 | Ready to receive, active low |

## Verification
The hardest state to reach is an overrun. It needs a second full frame to arrive while the first byte is still unread. The port must also be re-armed in between by a dummy write alone, with no read. The bench issues two dummy-write-and-frame pairs back to back without a read. It then checks that the second byte replaced the first, that `rts_out` stayed high, and that each of the three clear strobes acts only on its own flag.

// File: rtl/sync_serial_rx.sv
module sync_serial_rx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          rx_en,
  input  logic          txbuf_wr,
  input  logic          rxbuf_rd,
  input  logic          irq_clr,
  input  logic          ovr_clr,
  input  logic          sclk_in,
  input  logic          rxd_in,
  output logic [DW-1:0] rx_data,
  output logic          rx_done,
  output logic          irq_req,
  output logic          ovr_err,
  output logic          txbuf_empty,
  output logic          rts_out
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [1:0]    sclk_sync, rxd_sync;
  logic          sclk_d, busy, rts_q;
  logic [CW-1:0] cnt;
  logic [DW-1:0] shreg;

  wire rise      = sclk_sync[1] & ~sclk_d;
  wire fall      = ~sclk_sync[1] & sclk_d;
  wire armed     = tx_en & rx_en & ~txbuf_empty;
  wire start     = fall & ~busy & armed;
  wire frame_end = busy & rise & (cnt == LAST);
  wire [DW-1:0] next_sh = {rxd_sync[1], shreg[DW-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= 2'b11;
      rxd_sync  <= 2'b11;
      sclk_d    <= 1'b1;
    end else begin
      sclk_sync <= {sclk_sync[0], sclk_in};
      rxd_sync  <= {rxd_sync[0], rxd_in};
      sclk_d    <= sclk_sync[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      shreg <= '0;
    end else if (!rx_en) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy && rise) begin
      shreg <= next_sh;
      cnt   <= cnt + 1'b1;
      if (cnt == LAST) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_done     <= 1'b0;
      irq_req     <= 1'b0;
      ovr_err     <= 1'b0;
      txbuf_empty <= 1'b1;
      rts_q       <= 1'b0;
    end else begin
      if (txbuf_wr)   txbuf_empty <= 1'b0;
      else if (start) txbuf_empty <= 1'b1;

      if (frame_end) begin
        rx_data <= next_sh;
        rx_done <= 1'b1;
        irq_req <= 1'b1;
      end else begin
        if (rxbuf_rd) rx_done <= 1'b0;
        if (irq_clr)  irq_req <= 1'b0;
      end

      if (frame_end && rx_done) ovr_err <= 1'b1;
      else if (ovr_clr)         ovr_err <= 1'b0;

      if (start)                                    rts_q <= 1'b1;
      else if (rxbuf_rd && rx_done && !frame_end)   rts_q <= 1'b0;
    end
  end

  assign rts_out = rts_q | ~rx_en;
endmodule

// File: rtl/sync_serial_rx_chk.sv
module sync_serial_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic txbuf_wr,
  input logic rxbuf_rd,
  input logic irq_clr,
  input logic ovr_clr,
  input logic rx_done,
  input logic irq_req,
  input logic ovr_err,
  input logic txbuf_empty,
  input logic rts_out
);
  AST_DONE_FALL_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) $fell(rx_done) |-> $past(rxbuf_rd)); // R6
  AST_RTS_HIGH_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) !rx_en |-> rts_out); // R7
  AST_RTS_LOW_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) ($fell(rts_out) && $past(rx_en)) |-> $fell(rx_done)); // R7
  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovr_err) |-> (rx_done && $past(rx_done))); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) $fell(ovr_err) |-> $past(ovr_clr)); // R8
  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq_req) |-> rx_done); // R5
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) $fell(irq_req) |-> $past(irq_clr)); // R9
  AST_TXBUF_FILL: assert property (@(posedge clk) disable iff (!rst_n) $fell(txbuf_empty) |-> $past(txbuf_wr)); // R4
endmodule

bind sync_serial_rx sync_serial_rx_chk u_chk (.*);

// File: tb/sync_serial_rx_bench.sv
module sync_serial_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 0, rx_en = 0, txbuf_wr = 0, rxbuf_rd = 0, irq_clr = 0, ovr_clr = 0;
  logic sclk_in = 1'b1, rxd_in = 1'b1;
  logic [7:0] rx_data;
  logic rx_done, irq_req, ovr_err, txbuf_empty, rts_out;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sync_serial_rx u_sync_serial_rx (.*);

  localparam logic [7:0] VEC [6] = '{8'hA5, 8'h01, 8'h80, 8'hFF, 8'h00, 8'h3C};

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) begin sclk_in = 1'b0; rxd_in = b[i]; end
      repeat (4) @(negedge clk);
      sclk_in = 1'b1;
      repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done", rx_done, 0);
    chk("R1 irq", irq_req, 0);
    chk("R1 ovr", ovr_err, 0);
    chk("R1 data", rx_data, 8'h00);
    chk("R1 txe", txbuf_empty, 1);
    chk("R1 rts disabled", rts_out, 1);
    tx_en = 1; rx_en = 1;
    @(negedge clk);
    chk("R1 rts enabled", rts_out, 0);

    foreach (VEC[k]) begin
      pulse(txbuf_wr);
      chk("R4 txe cleared", txbuf_empty, 0);
      send(VEC[k]);
      chk("R2 data", rx_data, VEC[k]);
      chk("R5 done", rx_done, 1);
      chk("R5 irq", irq_req, 1);
      chk("R4 txe set at start", txbuf_empty, 1);
      chk("R7 rts held at completion", rts_out, 1);
      pulse(rxbuf_rd);
      chk("R6 done cleared", rx_done, 0);
      chk("R7 rts low after read", rts_out, 0);
      pulse(irq_clr);
      chk("R9 irq cleared", irq_req, 0);
    end

    send(8'h5A);
    chk("R3 no dummy: done", rx_done, 0);
    chk("R3 no dummy: data", rx_data, 8'h3C);

    tx_en = 0;
    pulse(txbuf_wr);
    send(8'h5A);
    chk("R3 tx off: done", rx_done, 0);
    chk("R3 tx off: data", rx_data, 8'h3C);
    tx_en = 1; rx_en = 0;
    @(negedge clk);
    chk("R7 rts forced", rts_out, 1);
    send(8'h5A);
    chk("R3 rx off: done", rx_done, 0);
    rx_en = 1;
    @(negedge clk);
    chk("R7 rts ready again", rts_out, 0);

    send(8'h11);
    chk("R2 armed frame", rx_data, 8'h11);
    pulse(txbuf_wr);
    send(8'h22);
    chk("R8 ovr set", ovr_err, 1);
    chk("R8 overwrite", rx_data, 8'h22);
    chk("R7 rts still high", rts_out, 1);
    pulse(rxbuf_rd);
    chk("R8 ovr sticky on read", ovr_err, 1);
    chk("R9 irq held on read", irq_req, 1);
    pulse(irq_clr);
    chk("R9 irq clr", irq_req, 0);
    chk("R8 ovr unaffected by irq clr", ovr_err, 1);
    pulse(ovr_clr);
    chk("R8 ovr clr", ovr_err, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule